// File: doc/BRIEF.md
# Cascadable Pulse Accumulator Pair

This block counts rising edges on two external pulse inputs with a pair of byte-wide counters. Each input first crosses into the clock domain through a two-flop synchronizer, and a rising-edge detector turns it into a one-cycle count strobe. A control bit chains the pair into a single 16-bit accumulator. In that mode the upper counter advances only on a carry out of the lower one. When the upper counter rolls over, a sticky overflow flag is set. That flag can be gated onto an interrupt request line.

Software reaches the block through a small register bus with a write strobe and a combinational read path. The bus gives byte access to each counter and also a word access. A word access reads or loads both bytes in the same clock cycle, so the 16-bit value can never tear. Two separate byte reads can straddle a carry from the low byte into the high byte and return a pair that never existed.

Top module: `pulse_acc_pair`

## Requirements
- R1: After reset both counters are 0x00, the overflow flag is 0, both control bits are 0 and the interrupt output is low.
- R2: Each counter increments by one for every rising edge on its own pulse input. The new value is visible on the third rising clock edge after the first edge that samples the input high. An input held high counts only once.
- R3: A counter that increments from 0xFF wraps to 0x00.
- R4: With the cascade bit (bit 0 of the control register) set, a wrap of the lower counter advances the upper counter in the same clock edge, and the upper counter's own pulse input is ignored.
- R5: A wrap of the upper counter from 0xFF to 0x00 sets the overflow flag in both modes. The flag stays set until it is cleared.
- R6: Writing the status register with bit 0 = 1 clears the flag. Writing it with bit 0 = 0 has no effect. A wrap in the same cycle as a clear leaves the flag set.
- R7: The interrupt output equals the overflow flag ANDed with the interrupt enable bit (bit 1 of the control register).
- R8: A bus write to a counter in the same cycle as its increment loads the written value, and the increment is lost.
- R9: The bus address map is: 0 = control, 1 = status (flag in bit 0), 2 = upper byte, 3 = lower byte, 4 = word {upper, lower}. A byte write uses wdata[7:0]. A word write loads upper from wdata[15:8] and lower from wdata[7:0] in one cycle.
- R10: Reads are combinational from the current state. Byte values are zero-extended to 16 bits, and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pulse_lo_i | input | 1 | Asynchronous pulse input of the lower counter |
| pulse_hi_i | input | 1 | Asynchronous pulse input of the upper counter |
| bus_we_i | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr_i | input | 3 | Register address |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Combinational read data for bus_addr_i |
| ovf_irq_o | output | 1 | Overflow interrupt request |

## Verification
A pulse driven before clock edge 1 changes a counter on edge 3: two edges go through the synchronizer and one through the counter register. A bus write lands on the next edge. The flag and interrupt follow a wrap on that same edge. Read data follows the address with no register in the path. The bench keeps a behavioural model that applies exactly these delays from a history of sampled inputs. It changes all inputs on falling edges and compares read data and the interrupt one time unit after every falling edge. Directed checks sample the latency window edge by edge, and they line up a clear write and a wrap on the same edge.

// File: rtl/pacc_pkg.sv
package pacc_pkg;
  localparam int PACC_CNT_W  = 8;
  localparam int PACC_ADDR_W = 3;
  localparam int PACC_SYNC_N = 2;

  localparam logic [PACC_ADDR_W-1:0] ADDR_CTRL = 3'd0;
  localparam logic [PACC_ADDR_W-1:0] ADDR_STAT = 3'd1;
  localparam logic [PACC_ADDR_W-1:0] ADDR_HI   = 3'd2;
  localparam logic [PACC_ADDR_W-1:0] ADDR_LO   = 3'd3;
  localparam logic [PACC_ADDR_W-1:0] ADDR_WORD = 3'd4;

  // Control register bit positions
  localparam int CTRL_CASC_BIT = 0;
  localparam int CTRL_IE_BIT   = 1;
endpackage

// File: rtl/pacc_edge_sync.sv
module pacc_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], async_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;

  // One strobe per edge: a held input never yields two strobes in a row (R2)
  assert_single_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/pacc_counter.sv
module pacc_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  // Returns {carry, sum} of value + 1
  function automatic logic [W:0] step_up(input logic [W-1:0] v);
    return {1'b0, v} + (W+1)'(1);
  endfunction

  logic [W:0] stepped;
  assign stepped = step_up(cnt_o);
  assign wrap_o  = inc_i & ~load_i & stepped[W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_o <= '0;
    else if (load_i) cnt_o <= load_val_i;
    else if (inc_i)  cnt_o <= stepped[W-1:0];
  end

  assert_load_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> cnt_o == $past(load_val_i));

  assert_wrap_to_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_o |=> cnt_o == '0);
endmodule

// File: rtl/pacc_ctrl.sv
module pacc_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctrl_we_i,
  input  logic [1:0] ctrl_wdata_i,
  input  logic       clr_req_i,
  input  logic       set_evt_i,
  output logic       cascade_o,
  output logic       ovf_ie_o,
  output logic       ovf_flag_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cascade_o <= 1'b0;
      ovf_ie_o  <= 1'b0;
    end else if (ctrl_we_i) begin
      cascade_o <= ctrl_wdata_i[pacc_pkg::CTRL_CASC_BIT];
      ovf_ie_o  <= ctrl_wdata_i[pacc_pkg::CTRL_IE_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ovf_flag_o <= 1'b0;
    else if (set_evt_i) ovf_flag_o <= 1'b1;
    else if (clr_req_i) ovf_flag_o <= 1'b0;
  end

  assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt_i |=> ovf_flag_o);

  assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag_o && !clr_req_i) |=> ovf_flag_o);

  assert_flag_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag_o) |-> $past(set_evt_i));
endmodule

// File: rtl/pulse_acc_pair.sv
module pulse_acc_pair #(
  parameter int CNT_W  = pacc_pkg::PACC_CNT_W,
  parameter int ADDR_W = pacc_pkg::PACC_ADDR_W,
  parameter int SYNC_N = pacc_pkg::PACC_SYNC_N
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pulse_lo_i,
  input  logic                 pulse_hi_i,
  input  logic                 bus_we_i,
  input  logic [ADDR_W-1:0]    bus_addr_i,
  input  logic [2*CNT_W-1:0]   bus_wdata_i,
  output logic [2*CNT_W-1:0]   bus_rdata_o,
  output logic                 ovf_irq_o
);
  import pacc_pkg::*;
  localparam int DATA_W = 2 * CNT_W;
  localparam int N_CH   = 2;

  // Named internal events
  logic [N_CH-1:0] pulse_vec, rise_vec;
  logic            wr_ctrl, wr_stat, wr_hi, wr_lo, wr_word;
  logic            lo_wrap, hi_wrap, hi_inc;
  logic            cascade, ovf_ie, ovf_flag;
  logic [CNT_W-1:0] lo_cnt, hi_cnt, hi_load_val;

  assign pulse_vec = {pulse_hi_i, pulse_lo_i};

  for (genvar g = 0; g < N_CH; g++) begin : g_in
    pacc_edge_sync #(.STAGES(SYNC_N)) u_sync (
      .clk(clk), .rst_n(rst_n), .async_i(pulse_vec[g]), .rise_o(rise_vec[g])
    );
  end

  assign wr_ctrl = bus_we_i && (bus_addr_i == ADDR_W'(ADDR_CTRL));
  assign wr_stat = bus_we_i && (bus_addr_i == ADDR_W'(ADDR_STAT));
  assign wr_hi   = bus_we_i && (bus_addr_i == ADDR_W'(ADDR_HI));
  assign wr_lo   = bus_we_i && (bus_addr_i == ADDR_W'(ADDR_LO));
  assign wr_word = bus_we_i && (bus_addr_i == ADDR_W'(ADDR_WORD));

  pacc_counter #(.W(CNT_W)) u_lo (
    .clk(clk), .rst_n(rst_n),
    .load_i(wr_lo | wr_word), .load_val_i(bus_wdata_i[CNT_W-1:0]),
    .inc_i(rise_vec[0]), .cnt_o(lo_cnt), .wrap_o(lo_wrap)
  );

  assign hi_load_val = wr_word ? bus_wdata_i[DATA_W-1:CNT_W] : bus_wdata_i[CNT_W-1:0];
  assign hi_inc      = cascade ? lo_wrap : rise_vec[1];

  pacc_counter #(.W(CNT_W)) u_hi (
    .clk(clk), .rst_n(rst_n),
    .load_i(wr_hi | wr_word), .load_val_i(hi_load_val),
    .inc_i(hi_inc), .cnt_o(hi_cnt), .wrap_o(hi_wrap)
  );

  pacc_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .ctrl_we_i(wr_ctrl), .ctrl_wdata_i(bus_wdata_i[1:0]),
    .clr_req_i(wr_stat & bus_wdata_i[0]), .set_evt_i(hi_wrap),
    .cascade_o(cascade), .ovf_ie_o(ovf_ie), .ovf_flag_o(ovf_flag)
  );

  assign ovf_irq_o = ovf_flag & ovf_ie;

  always_comb begin
    bus_rdata_o = '0;
    case (bus_addr_i)
      ADDR_W'(ADDR_CTRL): begin
        bus_rdata_o[CTRL_CASC_BIT] = cascade;
        bus_rdata_o[CTRL_IE_BIT]   = ovf_ie;
      end
      ADDR_W'(ADDR_STAT): bus_rdata_o[0] = ovf_flag;
      ADDR_W'(ADDR_HI):   bus_rdata_o[CNT_W-1:0] = hi_cnt;
      ADDR_W'(ADDR_LO):   bus_rdata_o[CNT_W-1:0] = lo_cnt;
      ADDR_W'(ADDR_WORD): bus_rdata_o = {hi_cnt, lo_cnt};
      default:            bus_rdata_o = '0;
    endcase
  end

  // Carry from the lower byte lands in the upper byte on the same edge (R4)
  assert_cascade_carry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cascade && lo_wrap && !(wr_hi || wr_word)) |=> hi_cnt == $past(hi_cnt) + CNT_W'(1));

  // In cascade mode the upper input alone never moves the upper byte (R4)
  assert_hi_input_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cascade && !lo_wrap && !(wr_hi || wr_word)) |=> $stable(hi_cnt));
endmodule

// File: tb/pulse_acc_pair_tb.sv
module pulse_acc_pair_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        pulse_lo = 1'b0, pulse_hi = 1'b0, we = 1'b0;
  logic [2:0]  addr = 3'd4;
  logic [15:0] wdata = '0;
  wire  [15:0] rdata;
  wire         irq;

  int n_checks = 0, n_errors = 0;
  bit done = 0;

  // Reference model state
  int m_lo, m_hi, m_flag, m_casc, m_ie;
  int qlo[$], qhi[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  pulse_acc_pair u_dut (
    .clk(clk), .rst_n(rst_n), .pulse_lo_i(pulse_lo), .pulse_hi_i(pulse_hi),
    .bus_we_i(we), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .ovf_irq_o(irq)
  );

  function automatic int model_read(int a);
    case (a)
      0: return m_ie * 2 + m_casc;
      1: return m_flag;
      2: return m_hi;
      3: return m_lo;
      4: return m_hi * 256 + m_lo;
      default: return 0;
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, got, exp, $time);
    end
  endtask

  // Model: a strobe at an edge comes from samples taken two and three edges earlier
  always @(posedge clk) begin
    bit rl, rh, lw, hinc;
    int nlo, nhi;
    if (!rst_n) begin
      m_lo = 0; m_hi = 0; m_flag = 0; m_casc = 0; m_ie = 0;
      qlo = '{0, 0, 0}; qhi = '{0, 0, 0};
    end else begin
      rl = (qlo[1] == 1) && (qlo[2] == 0);
      rh = (qhi[1] == 1) && (qhi[2] == 0);
      lw = 0;
      nlo = m_lo;
      if (we && (addr == 3 || addr == 4)) nlo = wdata[7:0];
      else if (rl) begin
        if (m_lo == 255) begin nlo = 0; lw = 1; end
        else nlo = m_lo + 1;
      end
      hinc = (m_casc != 0) ? lw : rh;
      nhi = m_hi;
      if (we && addr == 2) nhi = wdata[7:0];
      else if (we && addr == 4) nhi = wdata[15:8];
      else if (hinc) begin
        if (m_hi == 255) begin nhi = 0; m_flag = 1; end
        else nhi = m_hi + 1;
      end
      if (!(hinc && m_hi == 255 && !(we && (addr == 2 || addr == 4))))
        if (we && addr == 1 && wdata[0]) m_flag = 0;
      if (we && addr == 0) begin m_casc = wdata[0]; m_ie = wdata[1]; end
      m_lo = nlo; m_hi = nhi;
      qlo.push_front(int'(pulse_lo)); void'(qlo.pop_back());
      qhi.push_front(int'(pulse_hi)); void'(qhi.pop_back());
    end
  end

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      check("R9/R10 model rdata", rdata, model_read(addr));
      check("R7 model irq", irq, (m_flag != 0 && m_ie != 0));
    end
  end

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0; addr = 3'd4;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] v);
    @(negedge clk); addr = a; #2; v = rdata;
  endtask

  task automatic pulse(input bit hi);
    @(negedge clk); if (hi) pulse_hi = 1'b1; else pulse_lo = 1'b1;
    repeat (2) @(negedge clk);
    pulse_hi = 1'b0; pulse_lo = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    for (int a = 0; a < 5; a++) begin rd(3'(a), v); check("R1 reset reg", v, 0); end
    check("R1 reset irq", irq, 0);

    // R2: latency of one pulse, independent mode
    @(negedge clk); addr = 3'd4; pulse_lo = 1'b1;
    @(negedge clk); #2; check("R2 no count after edge 1", rdata, 16'h0000);
    @(negedge clk); #2; check("R2 no count after edge 2", rdata, 16'h0000);
    @(negedge clk); #2; check("R2 count after edge 3", rdata, 16'h0001);
    // R2: held high counts once
    repeat (8) @(negedge clk);
    pulse_lo = 1'b0; repeat (3) @(negedge clk);
    rd(3'd4, v); check("R2 held input counts once", v, 16'h0001);
    repeat (4) pulse(1'b0);
    repeat (2) pulse(1'b1);
    rd(3'd4, v); check("R2 independent counts", v, 16'h0205);

    // R3: lower byte wraps without touching upper in independent mode
    wr(3'd3, 16'h00FE);
    repeat (2) pulse(1'b0);
    rd(3'd4, v); check("R3 lower wrap", v, 16'h0200);

    // R5/R7: upper wrap sets flag, irq gated by enable
    wr(3'd2, 16'h00FF);
    pulse(1'b1);
    rd(3'd1, v); check("R5 flag set by upper wrap", v, 1);
    rd(3'd2, v); check("R3 upper wrap to zero", v, 0);
    check("R7 irq low with enable off", irq, 0);
    wr(3'd0, 16'h0002);
    rd(3'd1, v); check("R7 irq high with enable on", irq, 1);
    // R6: writing 0 leaves the flag, writing 1 clears it
    wr(3'd1, 16'h0000);
    rd(3'd1, v); check("R6 write 0 ignored", v, 1);
    wr(3'd1, 16'h0001);
    rd(3'd1, v); check("R6 write 1 clears", v, 0);
    check("R7 irq low after clear", irq, 0);

    // R4: cascade carry and upper input ignored
    wr(3'd0, 16'h0003);
    wr(3'd4, 16'h00FF);
    pulse(1'b0);
    rd(3'd4, v); check("R4 carry into upper", v, 16'h0100);
    pulse(1'b1);
    rd(3'd4, v); check("R4 upper input ignored", v, 16'h0100);

    // R5: cascade overflow from 0xFFFF
    wr(3'd4, 16'hFFFF);
    pulse(1'b0);
    rd(3'd4, v); check("R5 cascade wraps to 0", v, 16'h0000);
    rd(3'd1, v); check("R5 cascade overflow flag", v, 1);
    check("R7 irq in cascade", irq, 1);

    // R6: wrap on the same edge as a clear keeps the flag
    wr(3'd1, 16'h0001);
    wr(3'd4, 16'hFFFF);
    @(negedge clk); pulse_lo = 1'b1;
    @(negedge clk);
    @(negedge clk); we = 1'b1; addr = 3'd1; wdata = 16'h0001;
    @(negedge clk); we = 1'b0; addr = 3'd4; pulse_lo = 1'b0;
    rd(3'd1, v); check("R6 set wins over clear", v, 1);
    rd(3'd4, v); check("R6 word after simultaneous wrap", v, 16'h0000);

    // R8: byte write beats a same-edge increment (independent mode)
    wr(3'd0, 16'h0000);
    wr(3'd3, 16'h0010);
    @(negedge clk); pulse_lo = 1'b1;
    @(negedge clk);
    @(negedge clk); we = 1'b1; addr = 3'd3; wdata = 16'h0040;
    @(negedge clk); we = 1'b0; addr = 3'd4; pulse_lo = 1'b0;
    repeat (3) @(negedge clk);
    rd(3'd3, v); check("R8 write beats increment", v, 16'h0040);

    // R9/R10: word write loads both bytes, byte reads zero-extended, unmapped reads 0
    wr(3'd4, 16'h12FE);
    rd(3'd2, v); check("R9 upper byte of word write", v, 16'h0012);
    rd(3'd3, v); check("R10 lower byte zero-extended", v, 16'h00FE);
    rd(3'd4, v); check("R9 word read", v, 16'h12FE);
    rd(3'd5, v); check("R10 unmapped reads 0", v, 0);
    rd(3'd7, v); check("R10 unmapped reads 0", v, 0);

    @(negedge clk); addr = 3'd4;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1;
      n_checks++; n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end
endmodule